// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block gathers interrupt events from seven sources inside a small peripheral. Each source sends a one-cycle pulse. The pulse sets a sticky flag bit that stays set until the CPU clears it. A byte-wide register bus gives the CPU access to two registers: a flag register at offset 0xD and an enable register at offset 0xE. When a flag is set and its enable bit is also set, the block raises a level interrupt request.

To clear flags, software writes ones to the flag register. To change the enable mask, software writes the enable register, and bit 7 of the written byte selects the action. If bit 7 is 1, every 1 in bits 6:0 sets the matching enable bit. If bit 7 is 0, every 1 in bits 6:0 clears the matching enable bit. Bit 7 of a flag read is a live summary of the stored flags and is not stored itself. Bit 7 of an enable read always returns 1. Source 6 is reserved for the primary timer. The other sources are generic.

The read data and the request output are both registered. Each one changes one clock edge after the state that drives it.

Top module: `irq_ctl_top`

## Requirements
- R1: Synchronous active-high reset clears all flag bits and all enable bits, and drives `irq` and `rdata` to 0.
- R2: A 1 on `evt[i]` for one cycle sets flag bit i at that clock edge. The bit stays set until software clears it. Bit 6 is the primary timer source.
- R3: A write to offset 0xD clears each flag bit whose `wdata` bit (6:0) is 1. Flag bits written with 0 keep their value.
- R4: A read of offset 0xD returns the stored flags in bits 6:0. Bit 7 is 1 exactly when any of bits 6:0 is 1.
- R5: A write to offset 0xE with `wdata[7]`=1 sets each enable bit whose `wdata` bit (6:0) is 1. Other enable bits keep their value.
- R6: A write to offset 0xE with `wdata[7]`=0 clears each enable bit whose `wdata` bit (6:0) is 1. Other enable bits keep their value.
- R7: A read of offset 0xE returns the enable bits in bits 6:0, with bit 7 always 1.
- R8: `irq` is 1 in the cycle after any bit position has both its flag and its enable set. It is 0 in the cycle after no such position exists.
- R9: If an event and a flag-clear write hit the same flag bit in one cycle, the flag ends up set.
- R10: Writes to offsets other than 0xD and 0xE leave both registers unchanged. Reads of those offsets return 0x00.
- R11: `rdata` takes the read result at the edge where `sel`=1 and `wr`=0. It then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Bus access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt | input | 7 | Source event pulses, one bit per source |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
On every clock, the assertions check the following:
- An event sets its flag (R2).
- A flag write clears the selected bits when no event arrives at the same time (R3).
- The set and clear encodings of an enable write act on the masked bits (R5, R6).
- The flag summary bit and the enable read bit 7 are correct (R4, R7).
- `irq` follows flag AND enable one cycle later (R8).
- The registers and outputs are clear after reset (R1).

Other behaviours only the bench scenarios can show:
- An event that arrives together with a clear survives it (R9).
- Unused offsets leave the registers unchanged and read as zero (R10).
- `rdata` holds its value across idle cycles and writes (R11).
- Reset in the middle of a run clears the registers.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  // Decoded bus operation for one cycle
  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_FLAG_WR  = 3'd1,
    OP_MASK_WR  = 3'd2,
    OP_FLAG_RD  = 3'd3,
    OP_MASK_RD  = 3'd4,
    OP_OTHER_RD = 3'd5
  } bus_op_e;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_ctl_pkg::*;
#(
  parameter int AW       = 4,
  parameter int FLAG_OFS = 13,
  parameter int EN_OFS   = 14
) (
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output bus_op_e       op
);
  localparam logic [AW-1:0] FLAG_A = AW'(FLAG_OFS);
  localparam logic [AW-1:0] EN_A   = AW'(EN_OFS);

  always_comb begin
    op = OP_IDLE;
    if (sel) begin
      if (wr) begin
        if (addr == FLAG_A)    op = OP_FLAG_WR;
        else if (addr == EN_A) op = OP_MASK_WR;
      end else begin
        if (addr == FLAG_A)    op = OP_FLAG_RD;
        else if (addr == EN_A) op = OP_MASK_RD;
        else                   op = OP_OTHER_RD;
      end
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_en,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] flags
);
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_bit
      // An event that arrives in the same cycle as a clear keeps the bit set
      always_ff @(posedge clk) begin
        if (rst)
          flags[i] <= 1'b0;
        else if (evt[i])
          flags[i] <= 1'b1;
        else if (clr_en && clr_mask[i])
          flags[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            set_mode,
  input  logic [NSRC-1:0] sel_bits,
  output logic [NSRC-1:0] ena
);
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          ena[i] <= 1'b0;
        else if (wr_en && sel_bits[i])
          ena[i] <= set_mode;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_ctl_pkg::*;
#(
  parameter int NSRC = 7,
  localparam int DW  = NSRC + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  bus_op_e         op,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] ena,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (op)
      OP_FLAG_RD: rd_mux = {|flags, flags};
      OP_MASK_RD: rd_mux = {1'b1, ena};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (op == OP_FLAG_RD || op == OP_MASK_RD || op == OP_OTHER_RD)
        rdata <= rd_mux;
      irq <= |(flags & ena);
    end
  end
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int NSRC     = 7,
  parameter int AW       = 4,
  parameter int FLAG_OFS = 13,
  parameter int EN_OFS   = 14,
  localparam int DW      = NSRC + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NSRC-1:0] evt,
  output logic            irq
);
  bus_op_e         op;
  logic [NSRC-1:0] flags_w;
  logic [NSRC-1:0] ena_w;

  irq_bus_decode #(.AW(AW), .FLAG_OFS(FLAG_OFS), .EN_OFS(EN_OFS)) u_dec (
    .sel  (sel),
    .wr   (wr),
    .addr (addr),
    .op   (op)
  );

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .clr_en   (op == OP_FLAG_WR),
    .clr_mask (wdata[NSRC-1:0]),
    .flags    (flags_w)
  );

  irq_mask_bank #(.NSRC(NSRC)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (op == OP_MASK_WR),
    .set_mode (wdata[DW-1]),
    .sel_bits (wdata[NSRC-1:0]),
    .ena      (ena_w)
  );

  irq_readback #(.NSRC(NSRC)) u_rb (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .flags (flags_w),
    .ena   (ena_w),
    .rdata (rdata),
    .irq   (irq)
  );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int NSRC     = 7,
  parameter int AW       = 4,
  parameter int FLAG_OFS = 13,
  parameter int EN_OFS   = 14,
  localparam int DW      = NSRC + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            sel,
  input logic            wr,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic [NSRC-1:0] evt,
  input logic            irq,
  input logic [NSRC-1:0] flags_w,
  input logic [NSRC-1:0] ena_w
);
  localparam logic [AW-1:0] FLAG_A = AW'(FLAG_OFS);
  localparam logic [AW-1:0] EN_A   = AW'(EN_OFS);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_w == '0 && ena_w == '0 && irq == 1'b0 && rdata == '0));

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((flags_w & $past(evt)) == $past(evt)));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && addr == FLAG_A) |=>
      ((flags_w & $past(wdata[NSRC-1:0]) & ~$past(evt)) == '0));

  // R4
  flag_summary_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr && addr == FLAG_A) |=> (rdata[DW-1] == (|rdata[NSRC-1:0])));

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && addr == EN_A && wdata[DW-1]) |=>
      ((ena_w & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

  // R6
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && addr == EN_A && !wdata[DW-1]) |=>
      ((ena_w & $past(wdata[NSRC-1:0])) == '0));

  // R7
  mask_read_top_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr && addr == EN_A) |=> rdata[DW-1]);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(flags_w & ena_w))));
endmodule

bind irq_ctl_top irq_ctl_chk #(
  .NSRC(NSRC), .AW(AW), .FLAG_OFS(FLAG_OFS), .EN_OFS(EN_OFS)
) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .evt(evt), .irq(irq), .flags_w(flags_w), .ena_w(ena_w)
);

// File: tb/sim_irq_ctl_top.sv
`timescale 1ns/1ps
module sim_irq_ctl_top;
  localparam int NSRC = 7;
  localparam int AW   = 4;
  localparam int DW   = NSRC + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sel = 1'b0;
  logic            wr  = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic [NSRC-1:0] evt = '0;
  logic            irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          pend = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctl_top u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // Monitor: one expected item per issued read, compared a cycle later
  always @(posedge clk) pend <= sel && !wr && !rst;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", rdata, 8'hxx);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [NSRC-1:0] e);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d; evt = e;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; evt = '0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NSRC-1:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R1 rdata after reset", rdata, 8'h00);
    bus_rd(4'hD, 8'h00, "R1 flags after reset");
    bus_rd(4'hE, 8'h80, "R1 R7 enables after reset");

    pulse(7'h40);
    bus_rd(4'hD, 8'hC0, "R2 R4 timer flag");
    check("R8 irq masked", {7'd0, irq}, 8'h00);

    bus_wr(4'hE, 8'hC0, 7'h00);
    idle(1);
    check("R8 irq raised", {7'd0, irq}, 8'h01);
    bus_rd(4'hE, 8'hC0, "R5 R7 set timer enable");

    pulse(7'h05);
    bus_rd(4'hD, 8'hC5, "R2 more flags");
    bus_wr(4'hE, 8'h85, 7'h00);
    bus_rd(4'hE, 8'hC5, "R5 set keeps others");

    bus_wr(4'hD, 8'h41, 7'h00);
    bus_rd(4'hD, 8'h84, "R3 write one clears");
    check("R8 irq via bit2", {7'd0, irq}, 8'h01);
    bus_wr(4'hE, 8'h04, 7'h00);
    bus_rd(4'hE, 8'hC1, "R6 clear enable");
    check("R8 irq dropped", {7'd0, irq}, 8'h00);

    bus_wr(4'hD, 8'h05, 7'h01);
    bus_rd(4'hD, 8'h81, "R9 event beats clear");

    bus_wr(4'h3, 8'hFF, 7'h00);
    bus_wr(4'hF, 8'hFF, 7'h00);
    bus_rd(4'hD, 8'h81, "R10 flags untouched");
    bus_rd(4'hE, 8'hC1, "R10 enables untouched");
    bus_rd(4'h3, 8'h00, "R10 other offset reads zero");

    bus_rd(4'hE, 8'hC1, "R11 read value");
    idle(2);
    bus_wr(4'h3, 8'h55, 7'h00);
    check("R11 rdata held", rdata, 8'hC1);

    bus_wr(4'hD, 8'h7F, 7'h00);
    bus_rd(4'hD, 8'h00, "R3 R4 all cleared");
    check("R8 irq none", {7'd0, irq}, 8'h00);

    bus_wr(4'hE, 8'hFF, 7'h00);
    pulse(7'h7F);
    idle(1);
    check("R8 irq all sources", {7'd0, irq}, 8'h01);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    check("R1 irq after mid reset", {7'd0, irq}, 8'h00);
    bus_rd(4'hD, 8'h00, "R1 flags after mid reset");
    bus_rd(4'hE, 8'h80, "R1 enables after mid reset");

    idle(2);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule